// File: doc/BRIEF.md
# Pausing Interrupt Status Controller

This block sits beside a FIFO-based I2C transfer engine. It gathers the engine's one-cycle event pulses into sticky status bits, qualifies them with a software enable mask, and drives one level-sensitive interrupt request. Software acknowledges events by writing ones to a clear register.

The block also provides flow control. While any status bit is set, it tells the engine to hold at the next byte boundary. A byte already on the wire, including its acknowledge bit, always finishes first. Clearing the pending bits releases the engine, so the interrupt acknowledge also acts as the "continue" command. The stall does not depend on the enable mask: a masked event still holds the transfer.

Top module: `xfer_irq_pause`

## Requirements
- R1: After reset the status and enable registers read zero, and `irq_o` and `pause_o` are low.
- R2: An event pulse on an implemented bit sets that status bit from the next cycle on. The bit stays set until it is cleared.
- R3: A write to address 2 clears every status bit written as 1. Bits written as 0 keep their value.
- R4: If an event on a bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R5: `irq_o` is high exactly while some status bit and its enable bit are both set.
- R6: Address 0 reads the status register and address 1 reads and writes the enable register. Address 2 reads zero. All three registers share one bit layout:
  - 9: transmit FIFO empty
  - 8: receive FIFO full
  - 7: transmit finished with STOP
  - 6: receive finished with STOP
  - 5: transmit byte count reached
  - 4: receive byte count reached
  - 2: no acknowledge
  - 1: arbitration lost
  
  Bits 3 and 0 always read 0 and ignore events and enable writes.
- R7: `pause_o` rises the cycle after a clock edge at which `byte_end_i` was high while status was non-zero.
- R8: While `byte_end_i` stays low, `pause_o` does not rise, even with status bits pending.
- R9: `pause_o` falls in the same cycle that the status register becomes all zero. Pausing ignores the enable mask.
- R10: Clearing only some of the pending bits leaves `pause_o` asserted.
- R11: Events on different bits in successive cycles accumulate. An example is receive-FIFO-full followed one cycle later by receive-count-reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 10 | Event pulses from the engine, one bit per status position |
| byte_end_i | input | 1 | Engine is between bytes this cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 clear |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt request |
| pause_o | output | 1 | Hold request to the engine |

## Verification
The assertions assume that events arrive only as one-cycle pulses. They also assume that the engine reports `byte_end_i` on cycles that are truly between bytes. Beyond that, any mix of event, write and boundary inputs is legal.

The random stimulus drives events sparsely and at random. Writes, including enable writes, clears and writes to address 0, are random, and boundary cycles are random. As a result, a clear sometimes collides with a fresh event, and the pause is sometimes requested while the engine is mid-byte. Directed cases pin down the collision, the partial clear and the case where a masked event still stalls the engine.

// File: rtl/xip_pkg.sv
package xip_pkg;
  localparam int unsigned XIP_W = 10;
  localparam int unsigned XIP_AW = 2;
  localparam logic [XIP_W-1:0] XIP_IMPL = 10'h3F6;

  typedef enum logic [XIP_AW-1:0] {
    XIP_A_STATUS = 2'd0,
    XIP_A_ENABLE = 2'd1,
    XIP_A_CLEAR  = 2'd2
  } xip_addr_e;

  // sticky update: new events win over a simultaneous clear
  function automatic logic [XIP_W-1:0] xip_next_status(
    input logic [XIP_W-1:0] cur,
    input logic [XIP_W-1:0] evt,
    input logic [XIP_W-1:0] clr,
    input logic [XIP_W-1:0] impl
  );
    return ((cur & ~clr) | evt) & impl;
  endfunction

  function automatic logic xip_irq(
    input logic [XIP_W-1:0] st,
    input logic [XIP_W-1:0] en
  );
    return |(st & en);
  endfunction
endpackage

// File: rtl/xip_status_bank.sv
module xip_status_bank
  import xip_pkg::*;
#(
  parameter logic [XIP_W-1:0] IMPL = XIP_IMPL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XIP_W-1:0] evt_i,
  input  logic [XIP_W-1:0] clr_i,
  output logic [XIP_W-1:0] st_q_o,
  output logic [XIP_W-1:0] st_d_o
);
  assign st_d_o = xip_next_status(st_q_o, evt_i, clr_i, IMPL);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q_o <= '0;
    else        st_q_o <= st_d_o;
  end
endmodule

// File: rtl/xip_enable_reg.sv
module xip_enable_reg
  import xip_pkg::*;
#(
  parameter logic [XIP_W-1:0] IMPL = XIP_IMPL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [XIP_W-1:0] wdata_i,
  output logic [XIP_W-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en_o <= '0;
    else if (wr_i) en_o <= wdata_i & IMPL;
  end
endmodule

// File: rtl/xip_pause_gate.sv
module xip_pause_gate
  import xip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_end_i,
  input  logic [XIP_W-1:0] st_q_i,
  input  logic [XIP_W-1:0] st_d_i,
  output logic             pause_o
);
  logic pend_now;   // something pending before this edge
  logic pend_next;  // something pending after this edge
  logic hold_q;

  assign pend_now  = |st_q_i;
  assign pend_next = |st_d_i;

  always_ff @(posedge clk) begin
    if (!rst_n)          hold_q <= 1'b0;
    else if (!pend_next) hold_q <= 1'b0;
    else                 hold_q <= hold_q | (byte_end_i & pend_now);
  end

  assign pause_o = hold_q;
endmodule

// File: rtl/xfer_irq_pause.sv
module xfer_irq_pause
  import xip_pkg::*;
#(
  parameter logic [XIP_W-1:0] IMPL = XIP_IMPL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XIP_W-1:0]  evt_i,
  input  logic              byte_end_i,
  input  logic              reg_wr_i,
  input  logic [XIP_AW-1:0] reg_addr_i,
  input  logic [XIP_W-1:0]  reg_wdata_i,
  output logic [XIP_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              pause_o
);
  logic             wr_en;
  logic             wr_clr;
  logic [XIP_W-1:0] clr_mask;
  logic [XIP_W-1:0] st_q;
  logic [XIP_W-1:0] st_d;
  logic [XIP_W-1:0] en_q;

  assign wr_en    = reg_wr_i && (reg_addr_i == XIP_A_ENABLE);
  assign wr_clr   = reg_wr_i && (reg_addr_i == XIP_A_CLEAR);
  assign clr_mask = wr_clr ? reg_wdata_i : '0;

  xip_status_bank #(.IMPL(IMPL)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_mask),
    .st_q_o(st_q), .st_d_o(st_d)
  );

  xip_enable_reg #(.IMPL(IMPL)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .wdata_i(reg_wdata_i), .en_o(en_q)
  );

  xip_pause_gate u_pause (
    .clk(clk), .rst_n(rst_n), .byte_end_i(byte_end_i),
    .st_q_i(st_q), .st_d_i(st_d), .pause_o(pause_o)
  );

  assign irq_o = xip_irq(st_q, en_q);

  always_comb begin
    case (reg_addr_i)
      XIP_A_STATUS: reg_rdata_o = st_q;
      XIP_A_ENABLE: reg_rdata_o = en_q;
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/xip_checker.sv
module xip_checker
  import xip_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XIP_W-1:0]  evt_i,
  input logic              byte_end_i,
  input logic              reg_wr_i,
  input logic [XIP_AW-1:0] reg_addr_i,
  input logic [XIP_W-1:0]  reg_wdata_i,
  input logic [XIP_W-1:0]  st_q,
  input logic [XIP_W-1:0]  en_q,
  input logic              irq_o,
  input logic              pause_o
);
  logic [XIP_W-1:0] evt_impl;
  assign evt_impl = evt_i & XIP_IMPL;

  // R2 and R4: a fresh event is always captured, clear or not
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_impl != '0) |=> ((st_q & $past(evt_impl)) == $past(evt_impl)));

  // R3: a clear without competing events removes the written bits
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == XIP_A_CLEAR && evt_i == '0) |=>
      ((st_q & $past(reg_wdata_i)) == '0));

  // R5: an interrupt implies a pending enabled cause
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((st_q & en_q) != '0));

  // R6: reserved positions never hold state
  a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[3] == 1'b0) && (st_q[0] == 1'b0) && (en_q[3] == 1'b0) && (en_q[0] == 1'b0));

  // R8: pause only begins after a byte boundary
  a_r8_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_o) |-> $past(byte_end_i));

  // R9: no pause with nothing pending
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> !pause_o);
endmodule

bind xfer_irq_pause xip_checker i_xip_checker (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .byte_end_i(byte_end_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .st_q(st_q), .en_q(en_q), .irq_o(irq_o), .pause_o(pause_o)
);

// File: tb/test_xfer_irq_pause.sv
`timescale 1ns/1ps
module test_xfer_irq_pause;
  localparam logic [9:0] IMPL = 10'h3F6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] evt_i = '0;
  logic       byte_end_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [9:0] reg_wdata_i = '0;
  logic [9:0] reg_rdata_o;
  logic       irq_o;
  logic       pause_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [9:0] m_st = '0;
  logic [9:0] m_en = '0;
  logic       m_hold = 1'b0;

  always #4 clk = ~clk;

  xfer_irq_pause i_xfer_irq_pause (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .byte_end_i(byte_end_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .pause_o(pause_o)
  );

  function automatic logic [9:0] exp_read(input logic [1:0] a);
    if (a == 2'd0) return m_st;
    if (a == 2'd1) return m_en;
    return 10'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [9:0] e, input logic wr, input logic [1:0] a,
                     input logic [9:0] d, input logic bb, input string tag);
    logic [9:0] clr;
    logic [9:0] nst;
    @(negedge clk);
    evt_i = e; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d; byte_end_i = bb;
    @(posedge clk);
    clr = (wr && a == 2'd2) ? d : 10'd0;
    nst = ((m_st & ~clr) | e) & IMPL;
    m_hold = (nst == 0) ? 1'b0 : (m_hold | (bb && m_st != 0));
    if (wr && a == 2'd1) m_en = d & IMPL;
    m_st = nst;
    #2;
    check(reg_rdata_o == exp_read(a), {tag, " rdata"}, reg_rdata_o, exp_read(a));
    check(irq_o == |(m_st & m_en), {tag, " irq"}, irq_o, |(m_st & m_en));
    check(pause_o == m_hold, {tag, " pause"}, pause_o, m_hold);
    evt_i = '0; reg_wr_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(10'h0, 0, 2'd0, 10'h0, 0, "R1 reset");
    check(reg_rdata_o == 0 && !irq_o && !pause_o, "R1 idle", reg_rdata_o, 0);
    cyc(10'h0, 1, 2'd1, 10'h3FF, 0, "R6 enable");
    check(reg_rdata_o == 10'h3F6, "R6 enable layout", reg_rdata_o, 10'h3F6);
    cyc(10'h200, 0, 2'd0, 10'h0, 0, "R2 set");
    check(reg_rdata_o == 10'h200, "R2 tx-empty", reg_rdata_o, 10'h200);
    check(irq_o == 1'b1, "R5 irq", irq_o, 1);
    cyc(10'h0, 0, 2'd0, 10'h0, 0, "R8 mid byte");
    check(pause_o == 1'b0, "R8 no pause mid byte", pause_o, 0);
    cyc(10'h0, 0, 2'd0, 10'h0, 1, "R7 boundary");
    check(pause_o == 1'b1, "R7 pause", pause_o, 1);
    cyc(10'h100, 0, 2'd0, 10'h0, 0, "R11 rx full");
    cyc(10'h010, 0, 2'd0, 10'h0, 0, "R11 rx count");
    check(reg_rdata_o == 10'h310, "R11 accumulate", reg_rdata_o, 10'h310);
    cyc(10'h0, 1, 2'd2, 10'h200, 0, "R10 partial clear");
    check(pause_o == 1'b1, "R10 still paused", pause_o, 1);
    cyc(10'h010, 1, 2'd2, 10'h110, 0, "R4 collision");
    cyc(10'h0, 0, 2'd0, 10'h0, 0, "R4 read");
    check(reg_rdata_o == 10'h010, "R4 event wins", reg_rdata_o, 10'h010);
    cyc(10'h0, 1, 2'd2, 10'h3FF, 0, "R3 clear all");
    check(pause_o == 1'b0 && !irq_o, "R9 release", pause_o, 0);
    cyc(10'h0, 1, 2'd1, 10'h0, 0, "R9 mask off");
    cyc(10'h004, 0, 2'd0, 10'h0, 1, "R9 masked event");
    cyc(10'h0, 0, 2'd0, 10'h0, 1, "R9 masked boundary");
    check(pause_o == 1'b1 && !irq_o, "R9 masked still pauses", pause_o, 1);
    cyc(10'h009, 0, 2'd0, 10'h0, 0, "R6 reserved");
    check(reg_rdata_o == 10'h004, "R6 reserved ignored", reg_rdata_o, 10'h004);
    cyc(10'h0, 1, 2'd2, 10'h004, 0, "R3 clear");
    check(reg_rdata_o == 10'h0, "R3 clear reads zero", reg_rdata_o, 0);
    for (int i = 0; i < 600; i++) begin
      logic [9:0] e;
      e = ($urandom % 6 == 0) ? 10'($urandom) : 10'h0;
      cyc(e, ($urandom % 3) == 0, 2'($urandom % 3), 10'($urandom),
          ($urandom % 4) == 0, "random R2 R3 R5 R7");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule